// File: doc/BRIEF.md
# Local Vector Interrupt Controller

This block is the interrupt controller that sits next to one processor core. It watches six local interrupt lines: timer, thermal, performance counter, external pin 0, external pin 1 and error. Each line has its own programmable entry that sets its vector number, delivery mode, active polarity, edge or level trigger, and a mask. Requests are collected in a 256-bit request register. Vectors the core has taken are held in a 256-bit in-service register. The block offers the core the highest pending vector whose priority class beats both the task-priority class and the class of the vector now in service.

Software reaches the block through a 32-bit register port. A write takes effect on the clock edge at which `bus_wr` is high. A read is combinational from `bus_addr`. The core takes an offered vector by raising `irq_ack_i` while `irq_o` is high. It retires the vector later by writing any value to the end-of-interrupt address. An entry in non-maskable mode drives a separate one-cycle pulse and never occupies a vector.

Top module: `lvec_intc`

## Requirements
- R1: After reset, each source entry reads 0x0001_0000 (masked, vector 0). Task priority (0x080) reads 0. The spurious register (0x0F0) reads 0x0FF: spurious vector 0xFF, enable bit 8 clear, focus-check-disable bit 9 clear. The active-vector register (0x0C0) reads 0x100. All request and in-service words read 0. `irq_o` and `nmi_o` are low.
- R2: The six source entries sit at 0x320 + n*0x10 in this order: timer (n=0), thermal, performance counter, pin 0, pin 1, error (n=5). Entry fields are:
  - bits 7:0: vector
  - bits 10:8: mode
  - bit 12: read-only pending status
  - bit 13: active low
  - bit 14: read-only remote flag
  - bit 15: level trigger
  - bit 16: mask

  Writing 0xFFFF_FFFF to an idle masked entry reads back 0x0001_A7FF, and leaves its neighbours unchanged.
- R3: On an unmasked edge-triggered entry in fixed mode (000) or external mode (111), a rising edge of the asserted level (line XOR bit 13) sets that vector's request bit. Request word k is read at 0x200 + k*0x10 and covers vectors 32k to 32k+31. While the bit is set, the entry's bit 12 reads 1.
- R4: A source whose entry has bit 16 set never sets a request bit.
- R5: Taking a level-triggered vector sets the entry's remote flag (bit 14). While the flag is set, the line raises no new request. End-of-interrupt for that vector clears the flag. If the line is still asserted, the vector is requested again on the next cycle.
- R6: Vectors 0 to 31 never become set in the request or in-service registers.
- R7: While spurious bit 8 is clear, `irq_o` stays low and no source sets a request bit.
- R8: `irq_o` is high, with `irq_vec_o` equal to the highest pending vector, only when that vector's bits 7:4 exceed task-priority bits 7:4. They must also exceed bits 7:4 of the highest in-service vector, when one exists.
- R9: Raising `irq_ack_i` while `irq_o` is high moves `irq_vec_o` from the request register to the in-service register. In-service word k is read at 0x100 + k*0x10.
- R10: Any write to 0x0B0, whatever its data, clears the highest set in-service bit. When no in-service bit is set, the write has no effect.
- R11: The active-vector register (0x0C0) gives the highest in-service vector in bits 7:0 with bit 8 clear. When nothing is in service it reads 0x100.
- R12: On an unmasked entry in non-maskable mode (100), a rising asserted edge gives a single-cycle `nmi_o` pulse on the next clock and sets no request bit. An entry in system-management mode (010) has no effect at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_SRC | Local interrupt lines, index = entry number |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | A vector is offered to the core |
| irq_vec_o | output | 8 | Offered vector |
| irq_ack_i | input | 1 | Core takes the offered vector |
| nmi_o | output | 1 | Non-maskable pulse |

## Verification
The properties assume that `irq_ack_i` is raised only as a response to an offer; an acknowledge while `irq_o` is low is dropped by the design. They also assume that no two entries share a vector while one of them is level-triggered. The directed tasks keep to both rules: they raise the acknowledge only after checking that `irq_o` is high, and they give every source its own vector. Polarity or trigger changes are made only while the affected line sits in a known state, because a change of polarity can itself look like an edge.

// File: rtl/lvec_pkg.sv
package lvec_pkg;
  localparam int VEC_W   = 8;
  localparam int NVEC    = 1 << VEC_W;
  localparam int WORD_W  = 32;
  localparam int NBANK   = NVEC / WORD_W;
  localparam int RSV_TOP = 32;

  localparam int OFS_TPR  = 'h080;
  localparam int OFS_EOI  = 'h0B0;
  localparam int OFS_ACT  = 'h0C0;
  localparam int OFS_SVR  = 'h0F0;
  localparam int OFS_ISR  = 'h100;
  localparam int OFS_REQ  = 'h200;
  localparam int OFS_ENT  = 'h320;
  localparam int OFS_STEP = 'h010;

  localparam logic [2:0] DM_FIXED = 3'b000;
  localparam logic [2:0] DM_SMI   = 3'b010;
  localparam logic [2:0] DM_NMI   = 3'b100;
  localparam logic [2:0] DM_EXT   = 3'b111;

  typedef struct packed {
    logic             mask;
    logic             lvl;
    logic             pol;
    logic [2:0]       mode;
    logic [VEC_W-1:0] vec;
  } ent_t;

  function automatic ent_t ent_from_word(input logic [WORD_W-1:0] w);
    ent_t e;
    e.vec  = w[7:0];
    e.mode = w[10:8];
    e.pol  = w[13];
    e.lvl  = w[15];
    e.mask = w[16];
    return e;
  endfunction

  function automatic logic [WORD_W-1:0] ent_to_word(input ent_t e, input logic pend,
                                                    input logic remote);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[7:0]   = e.vec;
    w[10:8]  = e.mode;
    w[12]    = pend;
    w[13]    = e.pol;
    w[14]    = remote;
    w[15]    = e.lvl;
    w[16]    = e.mask;
    return w;
  endfunction

  function automatic logic [3:0] cls(input logic [VEC_W-1:0] v);
    return v[7:4];
  endfunction

  function automatic logic is_reserved(input logic [VEC_W-1:0] v);
    return int'(v) < RSV_TOP;
  endfunction

  function automatic logic [NVEC-1:0] onehot(input logic [VEC_W-1:0] v);
    logic [NVEC-1:0] r;
    r    = '0;
    r[v] = 1'b1;
    return r;
  endfunction

  function automatic logic [VEC_W:0] scan_hi(input logic [NVEC-1:0] bits);
    logic [VEC_W:0] r;
    r = '0;
    for (int i = 0; i < NVEC; i++)
      if (bits[i]) r = {1'b1, VEC_W'(i)};
    return r;
  endfunction

  function automatic logic eligible(input logic [VEC_W-1:0] pend, input logic [VEC_W-1:0] tpr,
                                    input logic isr_any, input logic [VEC_W-1:0] isr_vec);
    return (cls(pend) > cls(tpr)) && (!isr_any || (cls(pend) > cls(isr_vec)));
  endfunction
endpackage

// File: rtl/lvec_scan.sv
module lvec_scan
  import lvec_pkg::*;
(
  input  logic [NVEC-1:0]  bits,
  output logic             any,
  output logic [VEC_W-1:0] idx
);
  logic [VEC_W:0] hit;
  assign hit = scan_hi(bits);
  assign any = hit[VEC_W];
  assign idx = hit[VEC_W-1:0];
endmodule

// File: rtl/lvec_entry.sv
module lvec_entry
  import lvec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              src,
  input  logic              glb_en,
  input  logic              pend,
  input  logic              acc_fire,
  input  logic [VEC_W-1:0]  acc_vec,
  input  logic              eoi_fire,
  input  logic [VEC_W-1:0]  eoi_vec,
  output logic              req_fire,
  output logic              nmi_fire,
  output logic [VEC_W-1:0]  vec,
  output logic [WORD_W-1:0] cfg
);
  ent_t ent_q;
  logic remote_q, prev_q;

  logic asserted, rising, live, to_core, ack_hit, eoi_hit, trig;
  assign asserted = src ^ ent_q.pol;
  assign rising   = asserted && !prev_q;
  assign live     = glb_en && !ent_q.mask;
  assign to_core  = (ent_q.mode == DM_FIXED) || (ent_q.mode == DM_EXT);
  assign ack_hit  = acc_fire && (acc_vec == ent_q.vec);
  assign eoi_hit  = eoi_fire && (eoi_vec == ent_q.vec);
  assign trig     = ent_q.lvl ? (asserted && !remote_q && !ack_hit) : rising;

  assign req_fire = live && to_core && trig && !is_reserved(ent_q.vec);
  assign nmi_fire = live && (ent_q.mode == DM_NMI) && rising;
  assign vec      = ent_q.vec;
  assign cfg      = ent_to_word(ent_q, pend, remote_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q      <= '0;
      ent_q.mask <= 1'b1;
      remote_q   <= 1'b0;
      prev_q     <= 1'b0;
    end else begin
      prev_q <= asserted;
      if (wr) ent_q <= ent_from_word(wdata);
      if (eoi_hit && ent_q.lvl)                 remote_q <= 1'b0;
      else if (ack_hit && ent_q.lvl && to_core) remote_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lvec_bank.sv
module lvec_bank
  import lvec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NVEC-1:0]  req_set,
  input  logic             acc_fire,
  input  logic [VEC_W-1:0] acc_vec,
  input  logic             eoi_fire,
  input  logic [VEC_W-1:0] eoi_vec,
  output logic [NVEC-1:0]  req_q,
  output logic [NVEC-1:0]  isr_q
);
  logic [NVEC-1:0] acc_mask, eoi_mask;
  assign acc_mask = acc_fire ? onehot(acc_vec) : '0;
  assign eoi_mask = eoi_fire ? onehot(eoi_vec) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      isr_q <= '0;
    end else begin
      req_q <= (req_q & ~acc_mask) | req_set;
      isr_q <= (isr_q & ~eoi_mask) | acc_mask;
    end
  end
endmodule

// File: rtl/lvec_intc.sv
module lvec_intc
  import lvec_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic [7:0]        irq_vec_o,
  input  logic              irq_ack_i,
  output logic              nmi_o
);
  logic [VEC_W-1:0] tpr_q, spur_vec_q;
  logic             glb_en_q, focus_off_q, nmi_q;

  logic [N_SRC-1:0]  ent_wr, ent_req, ent_nmi;
  logic [VEC_W-1:0]  ent_vec [N_SRC];
  logic [WORD_W-1:0] ent_cfg [N_SRC];

  logic [NVEC-1:0]  req_q, isr_q, req_set;
  logic             req_any, isr_any;
  logic [VEC_W-1:0] req_hi, isr_hi;

  logic tpr_wr, svr_wr, eoi_wr, eoi_fire, acc_fire;
  assign tpr_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_TPR));
  assign svr_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_SVR));
  assign eoi_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_EOI));
  assign eoi_fire = eoi_wr && isr_any;
  assign acc_fire = irq_ack_i && irq_o;

  lvec_scan u_req_scan (.bits(req_q), .any(req_any), .idx(req_hi));
  lvec_scan u_isr_scan (.bits(isr_q), .any(isr_any), .idx(isr_hi));

  for (genvar n = 0; n < N_SRC; n++) begin : g_ent
    localparam logic [ADDR_W-1:0] ENT_ADDR = ADDR_W'(OFS_ENT + n * OFS_STEP);
    assign ent_wr[n] = bus_wr && (bus_addr == ENT_ADDR);
    lvec_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ent_wr[n]),
      .wdata    (bus_wdata),
      .src      (src_i[n]),
      .glb_en   (glb_en_q),
      .pend     (req_q[ent_vec[n]]),
      .acc_fire (acc_fire),
      .acc_vec  (req_hi),
      .eoi_fire (eoi_fire),
      .eoi_vec  (isr_hi),
      .req_fire (ent_req[n]),
      .nmi_fire (ent_nmi[n]),
      .vec      (ent_vec[n]),
      .cfg      (ent_cfg[n])
    );
  end

  always_comb begin
    req_set = '0;
    for (int n = 0; n < N_SRC; n++)
      if (ent_req[n]) req_set = req_set | onehot(ent_vec[n]);
  end

  lvec_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_set  (req_set),
    .acc_fire (acc_fire),
    .acc_vec  (req_hi),
    .eoi_fire (eoi_fire),
    .eoi_vec  (isr_hi),
    .req_q    (req_q),
    .isr_q    (isr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q       <= '0;
      spur_vec_q  <= '1;
      glb_en_q    <= 1'b0;
      focus_off_q <= 1'b0;
      nmi_q       <= 1'b0;
    end else begin
      nmi_q <= |ent_nmi;
      if (tpr_wr) tpr_q <= bus_wdata[7:0];
      if (svr_wr) begin
        spur_vec_q  <= bus_wdata[7:0];
        glb_en_q    <= bus_wdata[8];
        focus_off_q <= bus_wdata[9];
      end
    end
  end

  assign irq_o     = glb_en_q && req_any && eligible(req_hi, tpr_q, isr_any, isr_hi);
  assign irq_vec_o = req_hi;
  assign nmi_o     = nmi_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_TPR)) bus_rdata = {24'b0, tpr_q};
    if (bus_addr == ADDR_W'(OFS_ACT)) bus_rdata = {23'b0, !isr_any, isr_hi};
    if (bus_addr == ADDR_W'(OFS_SVR)) bus_rdata = {22'b0, focus_off_q, glb_en_q, spur_vec_q};
    for (int k = 0; k < NBANK; k++) begin
      if (bus_addr == ADDR_W'(OFS_ISR + k * OFS_STEP)) bus_rdata = isr_q[k*WORD_W +: WORD_W];
      if (bus_addr == ADDR_W'(OFS_REQ + k * OFS_STEP)) bus_rdata = req_q[k*WORD_W +: WORD_W];
    end
    for (int n = 0; n < N_SRC; n++)
      if (bus_addr == ADDR_W'(OFS_ENT + n * OFS_STEP)) bus_rdata = ent_cfg[n];
  end
endmodule

// File: rtl/lvec_chk.sv
module lvec_chk
  import lvec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic [7:0]       irq_vec_o,
  input logic             irq_ack_i,
  input logic [NVEC-1:0]  req_q,
  input logic [NVEC-1:0]  isr_q,
  input logic             glb_en_q,
  input logic [VEC_W-1:0] tpr_q,
  input logic             eoi_fire,
  input logic             isr_any,
  input logic [VEC_W-1:0] isr_hi
);
  a_r6_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q[RSV_TOP-1:0] == '0) && (isr_q[RSV_TOP-1:0] == '0));

  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_q |-> !irq_o);

  a_r8_above_task_class: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_vec_o[7:4] > tpr_q[7:4]));

  a_r8_above_service_class: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && isr_any) |-> (irq_vec_o[7:4] > isr_hi[7:4]));

  a_r9_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_ack_i) |=> isr_q[$past(irq_vec_o)]);

  a_r10_eoi_retires_top: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |=> !isr_q[$past(isr_hi)]);
endmodule

bind lvec_intc lvec_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .irq_vec_o (irq_vec_o),
  .irq_ack_i (irq_ack_i),
  .req_q     (req_q),
  .isr_q     (isr_q),
  .glb_en_q  (glb_en_q),
  .tpr_q     (tpr_q),
  .eoi_fire  (eoi_fire),
  .isr_any   (isr_any),
  .isr_hi    (isr_hi)
);

// File: tb/test_lvec_intc.sv
`timescale 1ns/1ps
module test_lvec_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  src_i = '0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [7:0]  irq_vec_o;
  logic        irq_ack_i = 1'b0;
  logic        nmi_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  lvec_intc i_lvec_intc (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .irq_vec_o(irq_vec_o),
    .irq_ack_i(irq_ack_i), .nmi_o(nmi_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, $sformatf("read 0x%03h", a), bus_rdata, exp);
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); src_i[idx] = 1'b1;
    @(negedge clk); src_i[idx] = 1'b0;
  endtask

  task automatic take(input string req, input logic [7:0] exp_vec);
    check(req, "irq_o before ack", {31'b0, irq_o}, 32'd1);
    check(req, "offered vector", {24'b0, irq_vec_o}, {24'b0, exp_vec});
    @(negedge clk); irq_ack_i = 1'b1;
    @(negedge clk); irq_ack_i = 1'b0;
  endtask

  task automatic t_reset;
    for (int n = 0; n < 6; n++) rd_check("R1", 12'h320 + 12'(n * 16), 32'h0001_0000);
    rd_check("R1", 12'h080, 32'h0);
    rd_check("R1", 12'h0F0, 32'h0FF);
    rd_check("R1", 12'h0C0, 32'h100);
    for (int k = 0; k < 8; k++) begin
      rd_check("R1", 12'h100 + 12'(k * 16), 32'h0);
      rd_check("R1", 12'h200 + 12'(k * 16), 32'h0);
    end
    check("R1", "irq_o", {31'b0, irq_o}, 32'd0);
    check("R1", "nmi_o", {31'b0, nmi_o}, 32'd0);
  endtask

  task automatic t_layout;
    wr(12'h350, 32'hFFFF_FFFF);
    rd_check("R2", 12'h350, 32'h0001_A7FF);
    rd_check("R2", 12'h340, 32'h0001_0000);
    rd_check("R2", 12'h360, 32'h0001_0000);
    wr(12'h350, 32'h0001_0000);
    rd_check("R2", 12'h350, 32'h0001_0000);
  endtask

  task automatic t_edge;
    wr(12'h320, 32'h0000_0045);
    pulse(0);
    rd_check("R3", 12'h220, 32'h0000_0020);
    rd_check("R3", 12'h320, 32'h0000_1045);
    take("R3", 8'h45);
    rd_check("R9", 12'h220, 32'h0);
    rd_check("R9", 12'h120, 32'h0000_0020);
    rd_check("R11", 12'h0C0, 32'h045);
    check("R8", "irq_o while 0x45 in service", {31'b0, irq_o}, 32'd0);
    wr(12'h0B0, 32'h0000_DEAD);
    rd_check("R10", 12'h120, 32'h0);
    rd_check("R11", 12'h0C0, 32'h100);
    // active-low line: rests high, fires when it falls
    @(negedge clk); src_i[1] = 1'b1;
    wr(12'h330, 32'h0000_2050);
    rd_check("R3", 12'h220, 32'h0);
    @(negedge clk); src_i[1] = 1'b0;
    @(negedge clk);
    rd_check("R3", 12'h220, 32'h0001_0000);
    take("R3", 8'h50);
    wr(12'h0B0, 32'h0);
    rd_check("R10", 12'h120, 32'h0);
  endtask

  task automatic t_mask;
    wr(12'h340, 32'h0001_0060);
    pulse(2);
    rd_check("R4", 12'h230, 32'h0);
    check("R4", "irq_o", {31'b0, irq_o}, 32'd0);
  endtask

  task automatic t_reserved;
    wr(12'h340, 32'h0000_0010);
    pulse(2);
    rd_check("R6", 12'h200, 32'h0);
    rd_check("R6", 12'h100, 32'h0);
    check("R6", "irq_o", {31'b0, irq_o}, 32'd0);
  endtask

  task automatic t_disable;
    wr(12'h0F0, 32'h0000_00FF);
    pulse(0);
    rd_check("R7", 12'h220, 32'h0);
    check("R7", "irq_o", {31'b0, irq_o}, 32'd0);
    wr(12'h0F0, 32'h0000_01FF);
    rd_check("R7", 12'h220, 32'h0);
    check("R7", "irq_o after enable", {31'b0, irq_o}, 32'd0);
  endtask

  task automatic t_priority;
    wr(12'h080, 32'h50);
    wr(12'h350, 32'h0000_0048);
    pulse(3);
    rd_check("R8", 12'h220, 32'h0000_0100);
    check("R8", "0x48 blocked by task class", {31'b0, irq_o}, 32'd0);
    wr(12'h360, 32'h0000_0091);
    pulse(4);
    take("R8", 8'h91);
    rd_check("R9", 12'h140, 32'h0002_0000);
    wr(12'h080, 32'h0);
    check("R8", "0x48 blocked by service class", {31'b0, irq_o}, 32'd0);
    wr(12'h370, 32'h0000_00A3);
    pulse(5);
    take("R8", 8'hA3);
    rd_check("R11", 12'h0C0, 32'h0A3);
    wr(12'h0B0, 32'h0);
    rd_check("R10", 12'h0C0, 32'h091);
    check("R8", "0x48 still blocked", {31'b0, irq_o}, 32'd0);
    wr(12'h0B0, 32'h1234);
    rd_check("R11", 12'h0C0, 32'h100);
    take("R8", 8'h48);
    wr(12'h0B0, 32'h0);
    rd_check("R10", 12'h0C0, 32'h100);
    wr(12'h0B0, 32'hFFFF_FFFF);
    rd_check("R10", 12'h0C0, 32'h100);
    rd_check("R10", 12'h120, 32'h0);
    check("R10", "irq_o idle", {31'b0, irq_o}, 32'd0);
  endtask

  task automatic t_level;
    wr(12'h330, 32'h0000_8070);
    @(negedge clk); src_i[1] = 1'b1;
    @(negedge clk);
    rd_check("R5", 12'h230, 32'h0001_0000);
    take("R5", 8'h70);
    rd_check("R5", 12'h330, 32'h0000_C070);
    rd_check("R5", 12'h230, 32'h0);
    check("R5", "no re-offer while remote set", {31'b0, irq_o}, 32'd0);
    wr(12'h0B0, 32'h0);
    @(negedge clk);
    rd_check("R5", 12'h230, 32'h0001_0000);
    @(negedge clk); src_i[1] = 1'b0;
    take("R5", 8'h70);
    wr(12'h0B0, 32'h0);
    @(negedge clk);
    rd_check("R5", 12'h330, 32'h0000_8070);
    rd_check("R5", 12'h230, 32'h0);
  endtask

  task automatic t_nmi;
    wr(12'h360, 32'h0000_0499);
    @(negedge clk); src_i[4] = 1'b1;
    @(negedge clk);
    check("R12", "nmi pulse", {31'b0, nmi_o}, 32'd1);
    @(negedge clk);
    check("R12", "nmi pulse ends", {31'b0, nmi_o}, 32'd0);
    src_i[4] = 1'b0;
    rd_check("R12", 12'h240, 32'h0);
    check("R12", "irq_o after nmi", {31'b0, irq_o}, 32'd0);
    wr(12'h360, 32'h0000_029A);
    pulse(4);
    check("R12", "system-management mode no nmi", {31'b0, nmi_o}, 32'd0);
    @(negedge clk);
    check("R12", "system-management mode no nmi later", {31'b0, nmi_o}, 32'd0);
    rd_check("R12", 12'h240, 32'h0);
    check("R12", "system-management mode no irq", {31'b0, irq_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    wr(12'h0F0, 32'h0000_01FF);
    t_edge();
    t_mask();
    t_reserved();
    t_disable();
    t_priority();
    t_level();
    t_nmi();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule